// File: doc/BRIEF.md
# Parallel ADC Bus Host Sequencer

This block lets a synchronous system drive a successive-approximation converter that sits on a byte-wide parallel bus with active-low select, write and read strobes, a byte-select line and an active-low completion interrupt. A single start request with a configuration byte begins one full transaction. The block writes the byte to the converter, optionally waits an acquisition window and writes again, then waits for the completion interrupt. It reads the result as two bytes and hands back the 12-bit word with a one-cycle valid strobe.

Every bus strobe width is a whole number of system clock cycles. These counts are computed at elaboration from nanosecond minimums and the clock period parameter, so the same code meets the converter's setup, pulse-width and access times at any clock rate. Bit 5 of the configuration byte is decoded by the converter as its acquisition-mode select, and the sequencer uses that same bit to choose between the one-write and two-write sequences. A programmable timeout stops the sequence when the converter never answers.

Top module: `adcbus_host`

With the clock period parameter at 8000 ps, the derived phase lengths are: write setup SU = 8 cycles, write pulse WL = 8 cycles, read wait RW = 14 cycles, and read gap GP = 5 cycles.

## Requirements
- R1: After reset, cs_n_o, wr_n_o and rd_n_o are high, and hben_o, d_oe_o, busy_o, res_valid_o and timeout_err_o are low. d_o and res_o are zero.
- R2: Each write phase has three parts. First, SU = ceil(max(60 ns, 40 ns)/T) cycles with cs_n_o low, wr_n_o high and the byte driven (d_oe_o high). Second, WL = max(ceil(60 ns/T), ceil(100 ns/T) - SU - 1) cycles with wr_n_o low. Third, one hold cycle with wr_n_o high while cs_n_o stays low and the byte stays driven.
- R3: When bit 5 of the configuration byte is 0, exactly one write phase occurs. It is followed directly by the interrupt wait, during which cs_n_o is low and all other strobes are idle.
- R4: When bit 5 is 1, the first write phase is followed by an acquisition window of acq_len_i cycles, during which cs_n_o is high and the bus is released. A second write phase then occurs, driving the same byte with bit 5 cleared.
- R5: int_n_i is sampled on every clock of the interrupt wait. A low sample moves the sequence to the reads on the next cycle.
- R6: The low-byte read holds cs_n_o and rd_n_o low with hben_o low for RW = ceil(100 ns/T) + 1 cycles, and d_i[7:0] is captured on the last edge. Next, a gap of GP = ceil(40 ns/T) cycles has cs_n_o and rd_n_o high and hben_o high. Finally, the high-byte read repeats the RW-cycle pattern with hben_o high and captures d_i[3:0].
- R7: In the cycle after the second capture, res_o equals {high nibble, low byte} and res_valid_o is high for exactly one cycle. res_o then holds its value.
- R8: If int_n_i is not sampled low within max(timeout_i, 1) wait cycles, timeout_err_o is high for one cycle. No read occurs, and the block returns to idle.
- R9: busy_o rises in the cycle after an accepted start and stays high through the valid or error cycle, then falls. A start that arrives while busy_o is high has no effect on the sequence or on the bus.
- R10: An acq_len_i of 0 gives an acquisition window of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, taken only while idle |
| cfg_i | input | 8 | Configuration byte for the converter |
| acq_len_i | input | 16 | Acquisition window in cycles (two-write sequence) |
| timeout_i | input | 16 | Interrupt wait limit in cycles |
| int_n_i | input | 1 | Converter completion, active low, synchronous to clk |
| d_i | input | 8 | Read data from the converter bus |
| cs_n_o | output | 1 | Chip select, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| hben_o | output | 1 | Byte select: 0 low byte, 1 high nibble |
| d_o | output | 8 | Write data toward the bus |
| d_oe_o | output | 1 | Write data drive enable |
| busy_o | output | 1 | Transaction in progress |
| res_o | output | 12 | Assembled conversion result |
| res_valid_o | output | 1 | One-cycle result strobe |
| timeout_err_o | output | 1 | One-cycle interrupt timeout flag |

## Verification
A wrong phase counter or a wrong state shows up immediately on the strobes. In the very cycle the sequencer takes a wrong turn, a strobe edge moves by one or more cycles, or the chip select or the drive enable appears in a phase where it should not. A skipped or extra write shows up as a missing or additional write-strobe pulse within the first few dozen cycles of a transaction. Byte assembly errors, such as swapped nibbles or a wrong capture edge, appear only at the single result strobe. For that reason, the converter model returns data that differ between the byte-select states and between the capture edge and its neighbours.

// File: rtl/adcbus_pkg.sv
package adcbus_pkg;

    localparam int unsigned ACQ_SEL_BIT = 5;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WSET,
        ST_WLOW,
        ST_WHOLD,
        ST_ACQ,
        ST_WAIT,
        ST_RDLO,
        ST_GAP,
        ST_RDHI,
        ST_DONE,
        ST_FAIL
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic wr_n;
        logic rd_n;
        logic hsel;
        logic drive;
    } bus_ctl_t;

    function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned period_ps);
        return (ns * 1000 + period_ps - 1) / period_ps;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adcbus_tick.sv
module adcbus_tick #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          zero_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/adcbus_seq.sv
module adcbus_seq
    import adcbus_pkg::*;
#(
    parameter int unsigned CW   = 16,
    parameter int unsigned SU   = 1,
    parameter int unsigned WL   = 1,
    parameter int unsigned RDW  = 1,
    parameter int unsigned GAPC = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [7:0]    cfg_i,
    input  logic [CW-1:0] acq_len_i,
    input  logic [CW-1:0] timeout_i,
    input  logic          int_n_i,
    input  logic          zero_i,
    output logic          load_o,
    output logic [CW-1:0] load_val_o,
    output logic          cap_lo_o,
    output logic          cap_hi_o,
    output bus_ctl_t      ctl_o,
    output logic [7:0]    wbyte_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          fail_o
);
    localparam logic [CW-1:0] SU_L  = CW'(SU - 1);
    localparam logic [CW-1:0] WL_L  = CW'(WL - 1);
    localparam logic [CW-1:0] RDW_L = CW'(RDW - 1);
    localparam logic [CW-1:0] GAP_L = CW'(GAPC - 1);
    localparam logic [7:0]    ACQ_CLR = ~(8'd1 << ACQ_SEL_BIT);

    seq_state_e    st_q, st_d;
    logic [7:0]    cfg_q;
    logic [CW-1:0] acq_q, to_q;
    logic          second_q;

    function automatic logic [CW-1:0] less_one(logic [CW-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            cfg_q    <= '0;
            acq_q    <= '0;
            to_q     <= '0;
            second_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && start_i) begin
                cfg_q    <= cfg_i;
                acq_q    <= acq_len_i;
                to_q     <= timeout_i;
                second_q <= 1'b0;
            end
            if (st_q == ST_ACQ && zero_i) begin
                second_q <= 1'b1;
            end
        end
    end

    always_comb begin
        st_d       = st_q;
        load_o     = 1'b0;
        load_val_o = '0;
        cap_lo_o   = 1'b0;
        cap_hi_o   = 1'b0;
        case (st_q)
            ST_IDLE: if (start_i) begin
                st_d = ST_WSET; load_o = 1'b1; load_val_o = SU_L;
            end
            ST_WSET: if (zero_i) begin
                st_d = ST_WLOW; load_o = 1'b1; load_val_o = WL_L;
            end
            ST_WLOW: if (zero_i) st_d = ST_WHOLD;
            ST_WHOLD: begin
                load_o = 1'b1;
                if (cfg_q[ACQ_SEL_BIT] && !second_q) begin
                    st_d = ST_ACQ; load_val_o = less_one(acq_q);
                end else begin
                    st_d = ST_WAIT; load_val_o = less_one(to_q);
                end
            end
            ST_ACQ: if (zero_i) begin
                st_d = ST_WSET; load_o = 1'b1; load_val_o = SU_L;
            end
            ST_WAIT: begin
                if (!int_n_i) begin
                    st_d = ST_RDLO; load_o = 1'b1; load_val_o = RDW_L;
                end else if (zero_i) begin
                    st_d = ST_FAIL;
                end
            end
            ST_RDLO: if (zero_i) begin
                st_d = ST_GAP; load_o = 1'b1; load_val_o = GAP_L; cap_lo_o = 1'b1;
            end
            ST_GAP: if (zero_i) begin
                st_d = ST_RDHI; load_o = 1'b1; load_val_o = RDW_L;
            end
            ST_RDHI: if (zero_i) begin
                st_d = ST_DONE; cap_hi_o = 1'b1;
            end
            ST_DONE: st_d = ST_IDLE;
            ST_FAIL: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ctl_o.cs_n  = !(st_q inside {ST_WSET, ST_WLOW, ST_WHOLD, ST_WAIT, ST_RDLO, ST_RDHI});
        ctl_o.wr_n  = (st_q != ST_WLOW);
        ctl_o.rd_n  = !(st_q inside {ST_RDLO, ST_RDHI});
        ctl_o.hsel  = (st_q inside {ST_GAP, ST_RDHI});
        ctl_o.drive = (st_q inside {ST_WSET, ST_WLOW, ST_WHOLD});
    end

    assign wbyte_o = !ctl_o.drive ? 8'h00 : (second_q ? (cfg_q & ACQ_CLR) : cfg_q);
    assign busy_o  = (st_q != ST_IDLE);
    assign done_o  = (st_q == ST_DONE);
    assign fail_o  = (st_q == ST_FAIL);
endmodule

// File: rtl/adcbus_capture.sv
module adcbus_capture (
    input  logic        clk,
    input  logic        rst,
    input  logic        cap_lo_i,
    input  logic        cap_hi_i,
    input  logic [7:0]  d_i,
    output logic [11:0] res_o
);
    logic [7:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q  <= '0;
            res_o <= '0;
        end else begin
            if (cap_lo_i) lo_q <= d_i;
            if (cap_hi_i) res_o <= {d_i[3:0], lo_q};
        end
    end
endmodule

// File: rtl/adcbus_host.sv
module adcbus_host
    import adcbus_pkg::*;
#(
    parameter int unsigned CLK_PS = 8000,
    parameter int unsigned CW     = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [7:0]    cfg_i,
    input  logic [CW-1:0] acq_len_i,
    input  logic [CW-1:0] timeout_i,
    input  logic          int_n_i,
    input  logic [7:0]    d_i,
    output logic          cs_n_o,
    output logic          wr_n_o,
    output logic          rd_n_o,
    output logic          hben_o,
    output logic [7:0]    d_o,
    output logic          d_oe_o,
    output logic          busy_o,
    output logic [11:0]   res_o,
    output logic          res_valid_o,
    output logic          timeout_err_o
);
    localparam int unsigned C40   = ns_to_cycles(40, CLK_PS);
    localparam int unsigned C60   = ns_to_cycles(60, CLK_PS);
    localparam int unsigned C100  = ns_to_cycles(100, CLK_PS);
    localparam int unsigned SU    = max2(max2(C60, C40), 1);
    localparam int unsigned WL_CS = (C100 > SU + 1) ? (C100 - SU - 1) : 1;
    localparam int unsigned WL    = max2(max2(C60, WL_CS), 1);
    localparam int unsigned RDW   = C100 + 1;
    localparam int unsigned GAPC  = max2(C40, 1);

    logic          load, zero, cap_lo, cap_hi;
    logic [CW-1:0] load_val;
    bus_ctl_t      ctl;

    adcbus_tick #(.CW(CW)) u_tick (
        .clk(clk), .rst(rst), .load_i(load), .load_val_i(load_val), .zero_o(zero)
    );

    adcbus_seq #(.CW(CW), .SU(SU), .WL(WL), .RDW(RDW), .GAPC(GAPC)) u_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .cfg_i(cfg_i),
        .acq_len_i(acq_len_i), .timeout_i(timeout_i), .int_n_i(int_n_i),
        .zero_i(zero), .load_o(load), .load_val_o(load_val),
        .cap_lo_o(cap_lo), .cap_hi_o(cap_hi), .ctl_o(ctl), .wbyte_o(d_o),
        .busy_o(busy_o), .done_o(res_valid_o), .fail_o(timeout_err_o)
    );

    adcbus_capture u_cap (
        .clk(clk), .rst(rst), .cap_lo_i(cap_lo), .cap_hi_i(cap_hi),
        .d_i(d_i), .res_o(res_o)
    );

    assign cs_n_o = ctl.cs_n;
    assign wr_n_o = ctl.wr_n;
    assign rd_n_o = ctl.rd_n;
    assign hben_o = ctl.hsel;
    assign d_oe_o = ctl.drive;
endmodule

// File: rtl/adcbus_host_chk.sv
module adcbus_host_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       cs_n_o,
    input logic       wr_n_o,
    input logic       rd_n_o,
    input logic       hben_o,
    input logic [7:0] d_o,
    input logic       d_oe_o,
    input logic       busy_o,
    input logic       res_valid_o,
    input logic       timeout_err_o
);
    p_wr_in_cs_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_n_o |-> (!cs_n_o && d_oe_o));

    p_wr_rise_hold_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_n_o) |-> (!cs_n_o && d_oe_o && $stable(d_o)));

    p_data_steady_r2: assert property (@(posedge clk) disable iff (rst)
        (!wr_n_o && !$past(wr_n_o)) |-> $stable(d_o));

    p_no_rd_wr_r6: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n_o && !wr_n_o));

    p_rd_in_cs_r6: assert property (@(posedge clk) disable iff (rst)
        !rd_n_o |-> !cs_n_o);

    p_hben_steady_r6: assert property (@(posedge clk) disable iff (rst)
        (!rd_n_o && !$past(rd_n_o)) |-> $stable(hben_o));

    p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |=> !res_valid_o);

    p_end_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        !(res_valid_o && timeout_err_o));

    p_busy_end_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> $past(res_valid_o || timeout_err_o));

    p_busy_start_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));
endmodule

bind adcbus_host adcbus_host_chk u_chk (
    .clk(clk), .rst(rst), .start_i(start_i), .cs_n_o(cs_n_o),
    .wr_n_o(wr_n_o), .rd_n_o(rd_n_o), .hben_o(hben_o), .d_o(d_o),
    .d_oe_o(d_oe_o), .busy_o(busy_o), .res_valid_o(res_valid_o),
    .timeout_err_o(timeout_err_o)
);

// File: tb/adcbus_host_test.sv
module adcbus_host_test;
    localparam int T_PS = 8000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [7:0]  cfg_i = '0;
    logic [15:0] acq_len_i = '0;
    logic [15:0] timeout_i = '0;
    logic        int_n_i = 1'b1;
    logic [7:0]  d_i = '0;
    logic        cs_n_o, wr_n_o, rd_n_o, hben_o, d_oe_o, busy_o;
    logic        res_valid_o, timeout_err_o;
    logic [7:0]  d_o;
    logic [11:0] res_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    adcbus_host #(.CLK_PS(T_PS), .CW(16)) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .cfg_i(cfg_i),
        .acq_len_i(acq_len_i), .timeout_i(timeout_i), .int_n_i(int_n_i),
        .d_i(d_i), .cs_n_o(cs_n_o), .wr_n_o(wr_n_o), .rd_n_o(rd_n_o),
        .hben_o(hben_o), .d_o(d_o), .d_oe_o(d_oe_o), .busy_o(busy_o),
        .res_o(res_o), .res_valid_o(res_valid_o), .timeout_err_o(timeout_err_o)
    );

    function automatic int cyc(int ns);
        return (ns * 1000 + T_PS - 1) / T_PS;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    int su, wl, rdw, gapc;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // expected vector: {cs_n, wr_n, rd_n, hben, oe, d[7:0]} ; status {busy, valid, err}
    logic [12:0] exp_bus[$];
    logic [2:0]  exp_st[$];
    string       exp_tag[$];

    task automatic push(input int n, input logic [12:0] b, input logic [2:0] s, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_bus.push_back(b);
            exp_st.push_back(s);
            exp_tag.push_back(tag);
        end
    endtask

    task automatic push_write(input logic [7:0] byt, input string tag);
        push(su, {5'b01101, byt}, 3'b100, tag);
        push(wl, {5'b00101, byt}, 3'b100, tag);
        push(1,  {5'b01101, byt}, 3'b100, tag);
    endtask

    task automatic run_txn(input logic [7:0] cfg, input int acq, input int to,
                           input int int_dly, input logic [11:0] val, input bit poke);
        int w0, to_eff, n;
        bit ok_path, seen_rd;
        logic [12:0] act;
        logic [2:0]  sact;
        exp_bus.delete(); exp_st.delete(); exp_tag.delete();
        push_write(cfg, "R2");
        if (cfg[5]) begin
            push(imax(acq, 1), {5'b11100, 8'h00}, 3'b100, (acq == 0) ? "R10" : "R4");
            push_write(cfg & 8'hDF, "R4");
        end
        w0 = exp_bus.size();
        to_eff = imax(to, 1);
        n = (int_dly < 0) ? to_eff + 1 : int_dly + 1;
        ok_path = (n <= to_eff);
        if (ok_path) begin
            push(n, {5'b01100, 8'h00}, 3'b100, cfg[5] ? "R5" : "R3");
            push(rdw, {5'b01000, 8'h00}, 3'b100, "R6");
            push(gapc, {5'b11110, 8'h00}, 3'b100, "R6");
            push(rdw, {5'b01010, 8'h00}, 3'b100, "R6");
            push(1, {5'b11100, 8'h00}, 3'b110, "R7");
        end else begin
            push(to_eff, {5'b01100, 8'h00}, 3'b100, "R8");
            push(1, {5'b11100, 8'h00}, 3'b101, "R8");
        end
        push(1, {5'b11100, 8'h00}, 3'b000, "R9");

        @(negedge clk);
        cfg_i = cfg; acq_len_i = 16'(acq); timeout_i = 16'(to); start_i = 1'b1;
        seen_rd = 1'b0;
        for (int idx = 0; idx < exp_bus.size(); idx++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (poke && idx >= 3 && idx < 6) begin
                start_i = 1'b1; cfg_i = ~cfg;
            end
            act  = {cs_n_o, wr_n_o, rd_n_o, hben_o, d_oe_o, d_o};
            sact = {busy_o, res_valid_o, timeout_err_o};
            check(act == exp_bus[idx], exp_tag[idx], $sformatf("bus cycle %0d", idx),
                  int'(act), int'(exp_bus[idx]));
            check(sact[2] == exp_st[idx][2], "R9", $sformatf("busy cycle %0d", idx),
                  int'(sact[2]), int'(exp_st[idx][2]));
            check(sact[1:0] == exp_st[idx][1:0], exp_tag[idx],
                  $sformatf("valid/err cycle %0d", idx), int'(sact[1:0]), int'(exp_st[idx][1:0]));
            if (exp_st[idx][1]) begin
                check(res_o == val, "R7", "assembled result", int'(res_o), int'(val));
            end
            if (!rd_n_o) seen_rd = 1'b1;
            int_n_i = !(int_dly >= 0 && idx >= w0 + int_dly && !seen_rd);
            if (rd_n_o) d_i = 8'h5A;
            else d_i = hben_o ? {4'hC, val[11:8]} : val[7:0];
        end
        int_n_i = 1'b1;
        d_i = 8'h00;
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        su   = imax(cyc(60), cyc(40));
        wl   = imax(cyc(60), (cyc(100) - su - 1 > 0) ? cyc(100) - su - 1 : 1);
        rdw  = cyc(100) + 1;
        gapc = cyc(40);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check({cs_n_o, wr_n_o, rd_n_o} == 3'b111, "R1", "strobes", int'({cs_n_o, wr_n_o, rd_n_o}), 7);
        check({hben_o, d_oe_o, busy_o, res_valid_o, timeout_err_o} == 5'b0, "R1", "flags",
              int'({hben_o, d_oe_o, busy_o, res_valid_o, timeout_err_o}), 0);
        check(d_o == 8'h00 && res_o == 12'h000, "R1", "data", int'({res_o, d_o}), 0);

        run_txn(8'h8C, 0, 100, 10, 12'hA5C, 1'b0);   // R3 internal acquisition
        run_txn(8'hA4, 6, 50, 0, 12'h3F1, 1'b1);     // R4 external, start ignored R9
        run_txn(8'hFF, 0, 40, 3, 12'hFFF, 1'b0);     // R10 zero acquisition length
        run_txn(8'h81, 0, 20, -1, 12'h000, 1'b0);    // R8 timeout
        run_txn(8'h02, 0, 0, -1, 12'h000, 1'b0);     // R8 zero timeout acts as one
        run_txn(8'h40, 0, 7, 6, 12'h001, 1'b0);      // R5 interrupt on last allowed cycle
        run_txn(8'h2A, 2, 30, 1, 12'h800, 1'b0);     // R4 and R6 high-bit result
        // R7 result held after completion
        @(negedge clk);
        check(res_o == 12'h800, "R7", "result held", int'(res_o), 'h800);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule